// File: doc/BRIEF.md
# Serial-Programmed Clock Output Enable Controller

This block takes one reference clock and hands out ten gated copies of it. Software sets which copies run by writing bytes over a two-wire serial bus. The bus has a serial clock and an open-drain data line. The block only receives; it has no read path. A transaction opens with a start condition and an address byte. A data stream follows. Bits arrive most significant first. Each data byte has a fixed position in the stream (byte 0, 1, 2, ...), and that position selects which outputs the byte controls. All outputs come out of reset running.

A separate output-enable pin acts at the pad level. The block does not drive the pads itself. Instead it presents, for each output, a clock value and a tri-state enable. The pad ring uses these to build the three-state driver. When the pin is low, every tri-state enable drops, whatever the register contents.

A disabled output sits at logic low. Each enable bit crosses into the reference clock domain through a synchroniser. It then takes effect only while the reference clock is low, so no output ever shows a shortened pulse. The bus inputs are oversampled by a system clock that is at least four times faster than the serial clock.

Top module: `clkgate_serial_ctrl`

## Requirements
- R1: After reset all ten enables are active, so each clock output follows the reference clock, and the block does not pull the data line low.
- R2: An address byte equal to 0xD2 on the wire (device address 1101001 followed by a 0 write bit) is acknowledged: the block pulls the data line low through the ninth serial clock pulse.
- R3: The block ignores an address byte with any other address, and also ignores an address byte with the read bit set (0xD3). It gives no acknowledge, leaves the enables unchanged, and acknowledges nothing more until the next start condition.
- R4: In an addressed write, every data byte is acknowledged, and its bits are taken most significant first.
- R5: Data byte 0 bit n (n = 0..3) sets the enable of output n. Bits 7..4 of byte 0 have no effect.
- R6: Data byte 1 bit n (n = 4..7) sets the enable of output n. Bits 3..0 of byte 1 have no effect.
- R7: Data byte 2 bit 7 sets the enable of output 9 and bit 6 sets the enable of output 8. Bits 5..0 of byte 2 have no effect.
- R8: Data bytes after byte 2 are acknowledged but change no enable.
- R9: A start condition that arrives without a stop before it (a repeated start) makes the next data byte count as byte 0 again.
- R10: When the output-enable pin is low, all ten tri-state enables are low. When the pin is high, all ten are high.
- R11: An output whose enable is 1 equals the reference clock. An output whose enable is 0 stays low. No output is high while the reference clock is low.
- R12: The acknowledge drive on the data line starts and stops only while the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock that oversamples the serial bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial bus clock |
| sda_in | input | 1 | Serial bus data line as seen on the wire |
| sda_pull_low | output | 1 | 1 pulls the data line low (acknowledge) |
| ref_clk | input | 1 | Reference clock to distribute |
| out_en | input | 1 | Global output enable, active high |
| clk_out | output | 10 | Gated clock outputs |
| clk_oe | output | 10 | Per-output tri-state enable for the pad drivers |

## Verification
Directed writes target one byte position at a time. Each write sets the bits that carry no function to the opposite value, so a wrong bit mapping or a byte counter that is off by one shows up as a wrong output. Separate transactions cover a mismatched address, a read request, streams longer than three bytes and a repeated start without a stop; these distinguish ignoring a transaction, discarding bytes and restarting the count. A seeded random mix of addresses, stream lengths, data values, stop-or-restart endings and output-enable levels is then compared with a bench model of the enable map. Outputs are sampled in both phases of the reference clock.

// File: rtl/cgsc_pkg.sv
package cgsc_pkg;

    localparam int NUM_CLK   = 10;
    localparam int BYTE_W    = 8;
    localparam int BITCNT_W  = $clog2(BYTE_W + 1);
    localparam int BYTEIDX_W = 2;
    localparam logic [BYTEIDX_W-1:0] IDX_DISCARD = 2'd3;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_ADDR_ACK,
        RX_DATA,
        RX_DATA_ACK
    } rx_state_e;

    typedef struct packed {
        rx_state_e              st;
        logic [BITCNT_W-1:0]    bit_cnt;
        logic [BYTE_W-1:0]      shreg;
        logic [BYTEIDX_W-1:0]   byte_idx;
        logic                   ack;
        logic [NUM_CLK-1:0]     en;
    } rx_regs_t;

    // Folds one received data byte into the enable vector by stream position.
    function automatic logic [NUM_CLK-1:0] merge_byte(
        input logic [NUM_CLK-1:0]   cur,
        input logic [BYTEIDX_W-1:0] idx,
        input logic [BYTE_W-1:0]    b
    );
        logic [NUM_CLK-1:0] r;
        r = cur;
        case (idx)
            2'd0: r[3:0] = b[3:0];
            2'd1: r[7:4] = b[7:4];
            2'd2: begin
                r[9] = b[7];
                r[8] = b[6];
            end
            default: r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cgsc_sync_edge.sv
module cgsc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rose,
    output logic fell
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
        prev_d  = chain_q[STAGES-1];
    end

    // Idle bus lines rest high, so reset to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign level = chain_q[STAGES-1];
    assign rose  = level & ~prev_q;
    assign fell  = ~level & prev_q;
endmodule

// File: rtl/cgsc_serial_rx.sv
module cgsc_serial_rx
    import cgsc_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_lvl,
    input  logic               scl_rose,
    input  logic               scl_fell,
    input  logic               sda_lvl,
    input  logic               sda_rose,
    input  logic               sda_fell,
    output logic               ack_drive,
    output logic [NUM_CLK-1:0] en_vec
);
    localparam logic [BYTE_W-1:0]   ADDR_WR  = {DEV_ADDR, 1'b0};
    localparam logic [BITCNT_W-1:0] FULL_CNT = BITCNT_W'(BYTE_W);

    rx_regs_t d, q;
    logic     bus_start, bus_stop;

    always_comb begin
        bus_start = sda_fell & scl_lvl;
        bus_stop  = sda_rose & scl_lvl;
        d = q;
        if (bus_start) begin
            d.st       = RX_ADDR;
            d.bit_cnt  = '0;
            d.byte_idx = '0;
            d.ack      = 1'b0;
        end else if (bus_stop) begin
            d.st  = RX_IDLE;
            d.ack = 1'b0;
        end else begin
            case (q.st)
                RX_ADDR, RX_DATA: begin
                    if (scl_rose && q.bit_cnt < FULL_CNT) begin
                        d.shreg   = {q.shreg[BYTE_W-2:0], sda_lvl};
                        d.bit_cnt = q.bit_cnt + 1'b1;
                    end else if (scl_fell && q.bit_cnt == FULL_CNT) begin
                        if (q.st == RX_ADDR) begin
                            if (q.shreg == ADDR_WR) begin
                                d.ack = 1'b1;
                                d.st  = RX_ADDR_ACK;
                            end else begin
                                d.st  = RX_IDLE;
                            end
                        end else begin
                            d.ack = 1'b1;
                            d.st  = RX_DATA_ACK;
                            if (q.byte_idx != IDX_DISCARD)
                                d.en = merge_byte(q.en, q.byte_idx, q.shreg);
                        end
                    end
                end
                RX_ADDR_ACK, RX_DATA_ACK: begin
                    if (scl_fell) begin
                        d.ack     = 1'b0;
                        d.bit_cnt = '0;
                        d.st      = RX_DATA;
                        if (q.st == RX_DATA_ACK && q.byte_idx != IDX_DISCARD)
                            d.byte_idx = q.byte_idx + 1'b1;
                    end
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= RX_IDLE;
            q.bit_cnt  <= '0;
            q.shreg    <= '0;
            q.byte_idx <= '0;
            q.ack      <= 1'b0;
            q.en       <= '1;
        end else begin
            q <= d;
        end
    end

    assign ack_drive = q.ack;
    assign en_vec    = q.en;
endmodule

// File: rtl/cgsc_clk_gate.sv
module cgsc_clk_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic en_async,
    output logic gclk
);
    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   hold_d, hold_q;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], en_async};
        hold_d = sync_q[SYNC_STAGES-1];
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    // Updated on the falling edge: the gate only changes during the low phase.
    always_ff @(negedge ref_clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 1'b1;
        else        hold_q <= hold_d;
    end

    assign gclk = ref_clk & hold_q;
endmodule

// File: rtl/clkgate_serial_ctrl.sv
module clkgate_serial_ctrl
    import cgsc_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1101001,
    parameter int         BUS_STAGES  = 2,
    parameter int         GATE_STAGES = 2,
    parameter int         N_OUT       = NUM_CLK
) (
    input  logic             sys_clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_pull_low,
    input  logic             ref_clk,
    input  logic             out_en,
    output logic [N_OUT-1:0] clk_out,
    output logic [N_OUT-1:0] clk_oe
);
    logic               scl_lvl, scl_rose, scl_fell;
    logic               sda_lvl, sda_rose, sda_fell;
    logic [NUM_CLK-1:0] en_vec;

    cgsc_sync_edge #(.STAGES(BUS_STAGES)) u_scl_sync (
        .clk(sys_clk), .rst_n(rst_n), .async_in(scl_in),
        .level(scl_lvl), .rose(scl_rose), .fell(scl_fell)
    );

    cgsc_sync_edge #(.STAGES(BUS_STAGES)) u_sda_sync (
        .clk(sys_clk), .rst_n(rst_n), .async_in(sda_in),
        .level(sda_lvl), .rose(sda_rose), .fell(sda_fell)
    );

    cgsc_serial_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
        .clk(sys_clk), .rst_n(rst_n),
        .scl_lvl(scl_lvl), .scl_rose(scl_rose), .scl_fell(scl_fell),
        .sda_lvl(sda_lvl), .sda_rose(sda_rose), .sda_fell(sda_fell),
        .ack_drive(sda_pull_low), .en_vec(en_vec)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        cgsc_clk_gate #(.SYNC_STAGES(GATE_STAGES)) u_gate (
            .ref_clk(ref_clk), .rst_n(rst_n),
            .en_async(en_vec[i]), .gclk(clk_out[i])
        );
    end

    assign clk_oe = {N_OUT{out_en}};
endmodule

// File: rtl/cgsc_checker.sv
module cgsc_checker #(
    parameter int N_OUT = 10
) (
    input logic             sys_clk,
    input logic             rst_n,
    input logic             scl_in,
    input logic             sda_pull_low,
    input logic             ref_clk,
    input logic             out_en,
    input logic [N_OUT-1:0] clk_out,
    input logic [N_OUT-1:0] clk_oe
);
    assert_reset_no_ack_R1: assert property (@(posedge sys_clk) disable iff (!rst_n)
        $past(!rst_n) |-> !sda_pull_low);

    assert_oe_off_R10: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !out_en |-> clk_oe == '0);

    assert_oe_on_R10: assert property (@(posedge sys_clk) disable iff (!rst_n)
        out_en |-> &clk_oe);

    assert_low_phase_quiet_R11: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !ref_clk |-> clk_out == '0);

    assert_ack_start_scl_low_R12: assert property (@(posedge sys_clk) disable iff (!rst_n)
        $rose(sda_pull_low) |-> !scl_in);

    assert_ack_end_scl_low_R12: assert property (@(posedge sys_clk) disable iff (!rst_n)
        $fell(sda_pull_low) |-> !scl_in);
endmodule

bind clkgate_serial_ctrl cgsc_checker #(.N_OUT(N_OUT)) u_chk (
    .sys_clk(sys_clk), .rst_n(rst_n), .scl_in(scl_in),
    .sda_pull_low(sda_pull_low), .ref_clk(ref_clk), .out_en(out_en),
    .clk_out(clk_out), .clk_oe(clk_oe)
);

// File: tb/clkgate_serial_ctrl_tb_top.sv
module clkgate_serial_ctrl_tb_top;
    localparam int HALF = 10;

    logic       sys_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       scl_m   = 1'b1;
    logic       sda_m   = 1'b1;
    logic       out_en  = 1'b1;
    logic       sda_line;
    logic       sda_pull_low;
    logic [9:0] clk_out, clk_oe;
    logic [9:0] exp_en = 10'h3FF;
    int         checks = 0;
    int         errors = 0;
    bit         done   = 1'b0;

    always #4  sys_clk = ~sys_clk;
    always #11 ref_clk = ~ref_clk;

    assign sda_line = sda_m & ~sda_pull_low;

    clkgate_serial_ctrl dut_i (
        .sys_clk(sys_clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull_low(sda_pull_low), .ref_clk(ref_clk), .out_en(out_en),
        .clk_out(clk_out), .clk_oe(clk_oe)
    );

    function automatic logic [9:0] model_byte(input logic [9:0] cur, input int idx,
                                              input logic [7:0] b);
        logic [9:0] r = cur;
        if (idx == 0) for (int k = 0; k < 4; k++) r[k] = b[k];
        if (idx == 1) for (int k = 4; k < 8; k++) r[k] = b[k];
        if (idx == 2) begin r[8] = b[6]; r[9] = b[7]; end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_sys(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic bus_start();
        wait_sys(4);
        sda_m = 1'b1; wait_sys(HALF);
        scl_m = 1'b1; wait_sys(HALF);
        sda_m = 1'b0; wait_sys(HALF);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_sys(4);
        sda_m = 1'b0; wait_sys(HALF);
        scl_m = 1'b1; wait_sys(HALF);
        sda_m = 1'b1; wait_sys(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic got_ack);
        for (int i = 7; i >= 0; i--) begin
            wait_sys(2);
            sda_m = b[i]; wait_sys(HALF);
            scl_m = 1'b1; wait_sys(HALF);
            scl_m = 1'b0;
        end
        wait_sys(2);
        sda_m = 1'b1; wait_sys(HALF);
        scl_m = 1'b1; wait_sys(HALF - 1);
        got_ack = ~sda_line;
        wait_sys(1);
        scl_m = 1'b0;
    endtask

    // Addressed transaction; the model and ack checks are derived from the requirements.
    task automatic txn(input logic [7:0] addr, input int n, input logic [7:0] b0,
                       input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3,
                       input logic [7:0] b4, input bit stop, input string req);
        logic       a;
        logic [7:0] bytes [5];
        bit         match;
        bytes[0] = b0; bytes[1] = b1; bytes[2] = b2; bytes[3] = b3; bytes[4] = b4;
        match = (addr == 8'hD2);
        bus_start();
        send_byte(addr, a);
        chk(a == match, match ? "R2 address ack" : "R3 address no ack", 32'(a), 32'(match));
        for (int k = 0; k < n; k++) begin
            send_byte(bytes[k], a);
            chk(a == match, match ? (k > 2 ? "R8 extra byte ack" : "R4 data ack")
                                  : "R3 data ignored", 32'(a), 32'(match));
            if (match) exp_en = model_byte(exp_en, k, bytes[k]);
        end
        if (stop) bus_stop();
    endtask

    task automatic check_outputs(input string req);
        repeat (5) @(posedge ref_clk);
        #5;
        chk(clk_out == exp_en, req, 32'(clk_out), 32'(exp_en));
        chk(clk_oe == {10{out_en}}, "R10 tri-state enables", 32'(clk_oe), 32'({10{out_en}}));
        @(negedge ref_clk);
        #5;
        chk(clk_out == 10'h000, "R11 low phase", 32'(clk_out), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge sys_clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        wait_sys(5);
        rst_n = 1'b1;
        wait_sys(3);
        chk(sda_pull_low == 1'b0, "R1 no ack after reset", 32'(sda_pull_low), 32'h0);
        check_outputs("R1 reset enables");

        txn(8'hD2, 1, 8'hF0, 0, 0, 0, 0, 1, "R5");
        check_outputs("R5 byte0 low nibble, high nibble ignored");
        txn(8'hD2, 2, 8'h0F, 8'h0F, 0, 0, 0, 1, "R6");
        check_outputs("R6 byte1 high nibble, low nibble ignored");
        txn(8'hD2, 3, 8'h0F, 8'hF0, 8'h7F, 0, 0, 1, "R7");
        check_outputs("R7 byte2 bits 7 and 6, reserved ignored");
        txn(8'hD2, 5, 8'h0F, 8'hF0, 8'hC0, 8'h00, 8'h00, 1, "R8");
        check_outputs("R8 bytes beyond 2 discarded");
        txn(8'hD3, 2, 8'h00, 8'h00, 0, 0, 0, 1, "R3");
        check_outputs("R3 read request ignored");
        txn(8'hA2, 3, 8'h00, 8'h00, 8'h00, 0, 0, 1, "R3");
        check_outputs("R3 wrong address ignored");
        txn(8'hD2, 2, 8'h0F, 8'h30, 0, 0, 0, 0, "R9");
        txn(8'hD2, 1, 8'h05, 0, 0, 0, 0, 1, "R9");
        check_outputs("R9 repeated start restarts at byte 0");
        out_en = 1'b0;
        check_outputs("R10 outputs with pin low");
        out_en = 1'b1;

        for (int t = 0; t < 30; t++) begin
            logic [7:0] addr;
            int         sel, n;
            sel  = int'($urandom_range(0, 9));
            addr = (sel < 7) ? 8'hD2 : (sel == 7 ? 8'hD3 : 8'($urandom_range(0, 255)));
            n    = int'($urandom_range(1, 5));
            out_en = 1'($urandom_range(0, 3) != 0);
            txn(addr, n, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                8'($urandom), 1'($urandom_range(0, 3) != 0), "R4");
            check_outputs("R11 random enable map");
        end
        bus_stop();

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule